// File: doc/BRIEF.md
# Stereo Audio Sample DMA Sequencer

This block sits between a stereo audio converter and an external DMA controller. It carries 16-bit samples in either direction. Capture mode moves samples from the converter to the bus. Playback mode moves samples from the bus to the converter. For each sample it raises as many DMA requests as the chosen transfer width needs. It presents or collects the matching part of the sample on each acknowledge, and it serves the enabled channels left first, then right. Software picks the direction, the transfer width, the request/acknowledge pair, the enabled channels and whether terminal count ends the run. It then issues a start pulse. The block latches that setup and holds `busy_o` high until the run ends.

The transfer-width code is 00 = byte (two units per sample, low byte first, byte on bus bits 7:0), 01 = word (one 16-bit unit), 10 = short (one unit holding only the sample's upper byte on bus bits 7:0) and 11 = prohibited. When the word-permission strap is low, word width is also refused. Terminal count, sampled on an acknowledge, ends the run after the current sample unless the ignore-terminal-count setting is on. With that setting on, an auto-reloading controller can stream without a stop. Pulling the DMA enable low returns the block to idle at once. Programmed I/O is then in use and no request is issued.

The sequencer uses six states:
- IDLE leads to WAIT on an accepted start.
- WAIT leads to UNIT0 when the converter is ready.
- UNIT0 leads to GAP on an acknowledge in byte width, and to COMMIT on an acknowledge in word or short width or when the run must stop.
- GAP always leads to UNIT1.
- UNIT1 leads to COMMIT on an acknowledge.
- COMMIT leads to IDLE if the run must stop, and otherwise to WAIT with the next channel selected.
- A low DMA enable forces IDLE from any state.

Top module: `adma_stream_seq`

## Requirements
- R1: After reset and whenever the block is not busy, `drq_o` is all zero, `conv_done_o` is 0 and `busy_o` is 0.
- R2: With width code 00, each sample takes two request/acknowledge units. The first unit carries sample bits 7:0 and the second carries bits 15:8, each on bus bits 7:0 with bus bits 15:8 zero in capture mode. `conv_done_o` pulses for exactly one cycle after the second acknowledge, and in playback `dac_data_o` then holds {second byte, first byte}.
- R3: With width code 01 and `word_ok_i` high, each sample takes one unit carrying all 16 bits in both directions. With `word_ok_i` low, a start with code 01 is refused: `busy_o` stays 0 and no request is raised.
- R4: With width code 10, each sample takes one unit. In capture, the bus carries sample bits 15:8 on bus bits 7:0. In playback, `dac_data_o` becomes {bus bits 7:0, 8'h00}.
- R5: A start with width code 11 is refused: `busy_o` stays 0 and no request is raised.
- R6: A request is raised only on `drq_o[cfg_pair]`, and the block responds only to `dack_i[cfg_pair]`.
- R7: A request is raised only after `conv_rdy_i` has been seen high while the block waits for a sample. The request falls in the cycle after its acknowledge is sampled.
- R8: With both channels enabled, samples alternate starting with left (`conv_ch_o` = 0 for left, 1 for right). With one channel enabled, every sample is for that channel.
- R9: `busy_o` rises the cycle after an accepted start and falls two cycles after an acknowledge sampled with `tc_i` high while terminal count is honoured.
- R10: With `cfg_no_tc` high, `tc_i` has no effect and the run continues sample after sample.
- R11: With `cfg_dma_en` low, a start is ignored, and a running transfer returns to idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dma_en | input | 1 | 1 = DMA transfer, 0 = programmed I/O (sequencer held idle) |
| cfg_start | input | 1 | One-cycle pulse that starts a run |
| cfg_width | input | 2 | Transfer width code: 00 byte, 01 word, 10 short, 11 prohibited |
| cfg_pair | input | SEL_W (1) | Request/acknowledge pair select |
| cfg_play | input | 1 | 0 = capture (converter to bus), 1 = playback (bus to converter) |
| cfg_no_tc | input | 1 | 1 = ignore terminal count |
| cfg_left_en | input | 1 | Left channel enabled |
| cfg_right_en | input | 1 | Right channel enabled |
| word_ok_i | input | 1 | Strap: word width permitted |
| conv_rdy_i | input | 1 | Converter has a sample ready (capture) or can accept one (playback) |
| adc_data_i | input | DATA_W (16) | Capture sample for the channel on `conv_ch_o` |
| conv_ch_o | output | 1 | Channel being served: 0 left, 1 right |
| conv_done_o | output | 1 | One-cycle pulse when a sample has been fully moved |
| dac_data_o | output | DATA_W (16) | Playback sample, valid while `conv_done_o` is high |
| drq_o | output | NUM_PAIRS (2) | DMA request per pair |
| dack_i | input | NUM_PAIRS (2) | DMA acknowledge per pair |
| tc_i | input | 1 | Terminal count, sampled with the acknowledge |
| bus_rd_o | output | DATA_W (16) | Capture data toward the bus, valid during an acknowledge |
| bus_wr_i | input | DATA_W (16) | Playback data from the bus, sampled on the acknowledge |
| busy_o | output | 1 | DMA run in progress |

## Verification
The assertions assume that the configuration inputs stay constant while `busy_o` is high, in particular `cfg_pair` and `cfg_no_tc`. They also assume that an acknowledge arrives only on a line whose request is up. The bench changes its setup only between runs, after `busy_o` has fallen. Its DMA model drives a single one-cycle acknowledge only after it has observed the request at a falling clock edge. It asserts `tc_i` only alongside that acknowledge.

// File: rtl/adma_pkg.sv
package adma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_UNIT0  = 3'd2,
        ST_GAP    = 3'd3,
        ST_UNIT1  = 3'd4,
        ST_COMMIT = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        XW_BYTE  = 2'b00,
        XW_WORD  = 2'b01,
        XW_SHORT = 2'b10,
        XW_BAD   = 2'b11
    } xfer_width_t;

    typedef struct packed {
        xfer_width_t width;
        logic        play;
        logic        no_tc;
        logic        use_l;
        logic        use_r;
    } xfer_cfg_t;

    function automatic logic width_allowed(xfer_width_t w, logic word_ok);
        return (w == XW_BYTE) || (w == XW_SHORT) || ((w == XW_WORD) && word_ok);
    endfunction

endpackage

// File: rtl/adma_chan_order.sv
module adma_chan_order (
    input  logic use_l,
    input  logic use_r,
    input  logic cur_ch,
    output logic next_ch
);
    // Both channels: alternate. One channel: stay on the enabled one.
    always_comb begin
        if (use_l && use_r)
            next_ch = ~cur_ch;
        else
            next_ch = use_l ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/adma_datapath.sv
module adma_datapath
    import adma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_width_t       width,
    input  logic              unit_hi,
    input  logic              ack_fire,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [DATA_W-1:0] bus_wr,
    output logic [DATA_W-1:0] bus_rd,
    output logic [DATA_W-1:0] dac_data
);
    localparam int HALF = DATA_W / 2;
    localparam logic [HALF-1:0] ZERO_HALF = '0;

    // Capture direction: pick the slice of the sample that this unit carries.
    always_comb begin
        if (unit_hi) begin
            bus_rd = {ZERO_HALF, adc_data[DATA_W-1:HALF]};
        end else begin
            unique case (width)
                XW_BYTE:  bus_rd = {ZERO_HALF, adc_data[HALF-1:0]};
                XW_WORD:  bus_rd = adc_data;
                XW_SHORT: bus_rd = {ZERO_HALF, adc_data[DATA_W-1:HALF]};
                default:  bus_rd = '0;
            endcase
        end
    end

    // Playback direction: assemble the sample from the acknowledged units.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_data <= '0;
        end else if (ack_fire) begin
            if (unit_hi) begin
                dac_data[DATA_W-1:HALF] <= bus_wr[HALF-1:0];
            end else begin
                unique case (width)
                    XW_BYTE:  dac_data[HALF-1:0] <= bus_wr[HALF-1:0];
                    XW_WORD:  dac_data <= bus_wr;
                    XW_SHORT: dac_data <= {bus_wr[HALF-1:0], ZERO_HALF};
                    default:  dac_data <= dac_data;
                endcase
            end
        end
    end
endmodule

// File: rtl/adma_seq_fsm.sv
module adma_seq_fsm
    import adma_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int SEL_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dma_en,
    input  logic                 start,
    input  logic [1:0]           width_in,
    input  logic [SEL_W-1:0]     pair_in,
    input  logic                 play_in,
    input  logic                 no_tc_in,
    input  logic                 use_l_in,
    input  logic                 use_r_in,
    input  logic                 word_ok,
    input  logic                 conv_rdy,
    input  logic [NUM_PAIRS-1:0] dack,
    input  logic                 tc,
    input  logic                 next_ch,
    output xfer_cfg_t            cfg_o,
    output logic                 cur_ch_o,
    output logic                 unit_hi_o,
    output logic                 ack_fire_o,
    output logic [NUM_PAIRS-1:0] drq_o,
    output logic                 busy_o,
    output logic                 conv_done_o
);
    seq_state_t       state_q, state_d;
    xfer_cfg_t        cfg_q;
    logic [SEL_W-1:0] pair_q;
    logic             ch_q;
    logic             stop_q;
    logic             launch;
    logic             in_unit;
    logic             ack_fire;
    logic             tc_stop;

    assign launch   = dma_en && start && (use_l_in || use_r_in)
                      && width_allowed(xfer_width_t'(width_in), word_ok);
    assign in_unit  = (state_q == ST_UNIT0) || (state_q == ST_UNIT1);
    assign ack_fire = in_unit && dack[pair_q];
    assign tc_stop  = tc && !cfg_q.no_tc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Run context: latched setup, current channel, stop flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pair_q <= '0;
            ch_q   <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && launch) begin
                cfg_q.width <= xfer_width_t'(width_in);
                cfg_q.play  <= play_in;
                cfg_q.no_tc <= no_tc_in;
                cfg_q.use_l <= use_l_in;
                cfg_q.use_r <= use_r_in;
                pair_q      <= pair_in;
                ch_q        <= use_l_in ? 1'b0 : 1'b1;
                stop_q      <= 1'b0;
            end
            if (ack_fire && tc_stop) stop_q <= 1'b1;
            if (state_q == ST_COMMIT) ch_q <= next_ch;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_WAIT;
            ST_WAIT:   if (conv_rdy) state_d = ST_UNIT0;
            ST_UNIT0:  if (ack_fire) begin
                           if (!tc_stop && cfg_q.width == XW_BYTE) state_d = ST_GAP;
                           else                                    state_d = ST_COMMIT;
                       end
            ST_GAP:    state_d = ST_UNIT1;
            ST_UNIT1:  if (ack_fire) state_d = ST_COMMIT;
            ST_COMMIT: state_d = stop_q ? ST_IDLE : ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
        if (!dma_en) state_d = ST_IDLE;
    end

    // Outputs
    always_comb begin
        drq_o = '0;
        if (in_unit) drq_o[pair_q] = 1'b1;
        busy_o      = (state_q != ST_IDLE);
        conv_done_o = (state_q == ST_COMMIT);
        unit_hi_o   = (state_q == ST_UNIT1);
        ack_fire_o  = ack_fire;
        cfg_o       = cfg_q;
        cur_ch_o    = ch_q;
    end
endmodule

// File: rtl/adma_stream_seq.sv
module adma_stream_seq
    import adma_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int NUM_PAIRS = 2,
    localparam int SEL_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_dma_en,
    input  logic                 cfg_start,
    input  logic [1:0]           cfg_width,
    input  logic [SEL_W-1:0]     cfg_pair,
    input  logic                 cfg_play,
    input  logic                 cfg_no_tc,
    input  logic                 cfg_left_en,
    input  logic                 cfg_right_en,
    input  logic                 word_ok_i,
    input  logic                 conv_rdy_i,
    input  logic [DATA_W-1:0]    adc_data_i,
    output logic                 conv_ch_o,
    output logic                 conv_done_o,
    output logic [DATA_W-1:0]    dac_data_o,
    output logic [NUM_PAIRS-1:0] drq_o,
    input  logic [NUM_PAIRS-1:0] dack_i,
    input  logic                 tc_i,
    output logic [DATA_W-1:0]    bus_rd_o,
    input  logic [DATA_W-1:0]    bus_wr_i,
    output logic                 busy_o
);
    xfer_cfg_t cfg;
    logic      cur_ch;
    logic      next_ch;
    logic      unit_hi;
    logic      ack_fire;

    adma_seq_fsm #(
        .NUM_PAIRS (NUM_PAIRS),
        .SEL_W     (SEL_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_en      (cfg_dma_en),
        .start       (cfg_start),
        .width_in    (cfg_width),
        .pair_in     (cfg_pair),
        .play_in     (cfg_play),
        .no_tc_in    (cfg_no_tc),
        .use_l_in    (cfg_left_en),
        .use_r_in    (cfg_right_en),
        .word_ok     (word_ok_i),
        .conv_rdy    (conv_rdy_i),
        .dack        (dack_i),
        .tc          (tc_i),
        .next_ch     (next_ch),
        .cfg_o       (cfg),
        .cur_ch_o    (cur_ch),
        .unit_hi_o   (unit_hi),
        .ack_fire_o  (ack_fire),
        .drq_o       (drq_o),
        .busy_o      (busy_o),
        .conv_done_o (conv_done_o)
    );

    adma_chan_order order_i (
        .use_l   (cfg.use_l),
        .use_r   (cfg.use_r),
        .cur_ch  (cur_ch),
        .next_ch (next_ch)
    );

    adma_datapath #(
        .DATA_W (DATA_W)
    ) dp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .width    (cfg.width),
        .unit_hi  (unit_hi),
        .ack_fire (ack_fire && cfg.play),
        .adc_data (adc_data_i),
        .bus_wr   (bus_wr_i),
        .bus_rd   (bus_rd_o),
        .dac_data (dac_data_o)
    );

    assign conv_ch_o = cur_ch;
endmodule

// File: rtl/adma_stream_seq_chk.sv
module adma_stream_seq_chk #(
    parameter  int DATA_W    = 16,
    parameter  int NUM_PAIRS = 2,
    localparam int SEL_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_dma_en,
    input logic                 cfg_start,
    input logic [1:0]           cfg_width,
    input logic [SEL_W-1:0]     cfg_pair,
    input logic                 cfg_no_tc,
    input logic                 word_ok_i,
    input logic [NUM_PAIRS-1:0] drq_o,
    input logic [NUM_PAIRS-1:0] dack_i,
    input logic                 tc_i,
    input logic                 busy_o,
    input logic                 conv_done_o
);
    logic [NUM_PAIRS-1:0] pair_mask;
    always_comb begin
        pair_mask = '0;
        pair_mask[cfg_pair] = 1'b1;
    end

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (drq_o == '0) && !conv_done_o);

    a_r2_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_o |=> !conv_done_o);

    a_r3_word_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cfg_start && cfg_width == 2'b01 && !word_ok_i) |=> !busy_o);

    a_r5_bad_width_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cfg_start && cfg_width == 2'b11) |=> !busy_o);

    a_r6_single_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drq_o) && ((drq_o & ~pair_mask) == '0));

    a_r7_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((drq_o & dack_i) != '0) |=> (drq_o == '0));

    a_r9_tc_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (((drq_o & dack_i) != '0) && tc_i && !cfg_no_tc) |=> ##1 !busy_o);

    a_r11_pio_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dma_en |=> !busy_o);
endmodule

bind adma_stream_seq adma_stream_seq_chk #(
    .DATA_W    (DATA_W),
    .NUM_PAIRS (NUM_PAIRS)
) chk_i (.*);

// File: tb/adma_stream_seq_tb.sv
`timescale 1ns/1ps
module adma_stream_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dma_en = 1'b1;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic [0:0]  cfg_pair = 1'b0;
    logic        cfg_play = 1'b0;
    logic        cfg_no_tc = 1'b0;
    logic        cfg_left_en = 1'b1;
    logic        cfg_right_en = 1'b0;
    logic        word_ok_i = 1'b1;
    logic        conv_rdy_i = 1'b1;
    logic [15:0] adc_data_i;
    logic        conv_ch_o;
    logic        conv_done_o;
    logic [15:0] dac_data_o;
    logic [1:0]  drq_o;
    logic [1:0]  dack_i = 2'b00;
    logic        tc_i = 1'b0;
    logic [15:0] bus_rd_o;
    logic [15:0] bus_wr_i = 16'h0;
    logic        busy_o;

    int          total = 0;
    int          bad = 0;
    logic [15:0] smp_idx = 16'h0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] smp_val(input logic [15:0] idx, input logic ch);
        return (16'h1234 + 16'h0111 * idx) ^ (ch ? 16'h8000 : 16'h0000);
    endfunction

    function automatic logic [15:0] wr_val(input logic [15:0] idx, input int u);
        return (u == 0) ? (16'hEE00 | ((idx * 16'd37 + 16'd5) & 16'h00FF))
                        : (16'h7700 | ((idx * 16'd91 + 16'd200) & 16'h00FF));
    endfunction

    assign adc_data_i = smp_val(smp_idx, conv_ch_o);

    adma_stream_seq dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_drq(input logic pr);
        for (int i = 0; i < 20; i++) begin
            if (drq_o[pr]) return;
            @(negedge clk);
        end
        chk("R7 request timeout", {31'b0, drq_o[pr]}, 32'd1);
    endtask

    task automatic run_xfer(input logic play, input logic [1:0] w, input logic pr,
                            input logic l, input logic r, input int nsamp);
        logic ch_exp;
        logic [15:0] exp_dac;
        int nunits;
        @(negedge clk);
        cfg_play = play; cfg_width = w; cfg_pair = pr;
        cfg_left_en = l; cfg_right_en = r; cfg_no_tc = 1'b0;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R9 busy after start", {31'b0, busy_o}, 32'd1);
        ch_exp = l ? 1'b0 : 1'b1;
        nunits = (w == 2'b00) ? 2 : 1;
        for (int s = 0; s < nsamp; s++) begin
            logic [15:0] d;
            d = smp_val(smp_idx, ch_exp);
            exp_dac = 16'h0;
            for (int u = 0; u < nunits; u++) begin
                logic [15:0] wv;
                wait_drq(pr);
                chk("R8 channel order", {31'b0, conv_ch_o}, {31'b0, ch_exp});
                chk("R6 pair select", {30'b0, drq_o}, pr ? 32'd2 : 32'd1);
                if (!play) begin
                    if (w == 2'b01)
                        chk("R3 word capture", {16'b0, bus_rd_o}, {16'b0, d});
                    else if (w == 2'b10)
                        chk("R4 short capture", {16'b0, bus_rd_o}, {24'b0, d[15:8]});
                    else
                        chk("R2 byte capture", {16'b0, bus_rd_o},
                            {24'b0, (u == 0) ? d[7:0] : d[15:8]});
                end
                wv = wr_val(smp_idx, u);
                if (w == 2'b01)      exp_dac = wv;
                else if (w == 2'b10) exp_dac = {wv[7:0], 8'h00};
                else if (u == 0)     exp_dac[7:0] = wv[7:0];
                else                 exp_dac[15:8] = wv[7:0];
                dack_i[pr] = 1'b1;
                bus_wr_i = wv;
                tc_i = (s == nsamp - 1) && (u == nunits - 1);
                @(negedge clk);
                dack_i = 2'b00;
                tc_i = 1'b0;
                chk("R7 request drops after ack", {30'b0, drq_o}, 32'd0);
            end
            chk("R2 sample done pulse", {31'b0, conv_done_o}, 32'd1);
            if (play) begin
                if (w == 2'b01)      chk("R3 word playback", {16'b0, dac_data_o}, {16'b0, exp_dac});
                else if (w == 2'b10) chk("R4 short playback", {16'b0, dac_data_o}, {16'b0, exp_dac});
                else                 chk("R2 byte playback", {16'b0, dac_data_o}, {16'b0, exp_dac});
            end
            smp_idx = smp_idx + 16'd1;
            if (l && r) ch_exp = ~ch_exp;
        end
        @(negedge clk);
        chk("R9 busy falls after tc", {31'b0, busy_o}, 32'd0);
    endtask

    task automatic refused_start(input string req, input logic [1:0] w);
        @(negedge clk);
        cfg_width = w; cfg_left_en = 1'b1; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(req, {29'b0, busy_o, drq_o}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {28'b0, busy_o, conv_done_o, drq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {28'b0, busy_o, conv_done_o, drq_o}, 32'd0);

        // Sweep: direction x width x pair x channel set
        for (int play = 0; play < 2; play++)
            for (int w = 0; w < 3; w++)
                for (int pr = 0; pr < 2; pr++)
                    for (int lr = 1; lr < 4; lr++)
                        run_xfer(play[0], w[1:0], pr[0], lr[1], lr[0], 3);

        // R5: prohibited width code
        refused_start("R5 width 11 refused", 2'b11);

        // R3: word refused by strap, byte still works
        word_ok_i = 1'b0;
        refused_start("R3 word refused by strap", 2'b01);
        run_xfer(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 2);
        word_ok_i = 1'b1;

        // R11: start ignored in programmed I/O mode
        cfg_dma_en = 1'b0;
        refused_start("R11 start ignored without DMA", 2'b01);
        cfg_dma_en = 1'b1;

        // R7: no request until converter ready
        @(negedge clk);
        conv_rdy_i = 1'b0;
        cfg_width = 2'b01; cfg_pair = 1'b0; cfg_play = 1'b0; cfg_no_tc = 1'b0;
        cfg_left_en = 1'b1; cfg_right_en = 1'b0; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R7 held until ready", {29'b0, busy_o, drq_o}, 32'd4);
            @(negedge clk);
        end
        conv_rdy_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 request after ready", {30'b0, drq_o}, 32'd1);
        dack_i[0] = 1'b1; tc_i = 1'b1;
        @(negedge clk);
        dack_i = 2'b00; tc_i = 1'b0;
        @(negedge clk);
        chk("R9 single-sample run ends", {31'b0, busy_o}, 32'd0);

        // R10: terminal count ignored, then R11 abort
        @(negedge clk);
        cfg_no_tc = 1'b1; cfg_width = 2'b01; cfg_left_en = 1'b0; cfg_right_en = 1'b1;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        for (int s = 0; s < 4; s++) begin
            wait_drq(1'b0);
            chk("R8 right-only channel", {31'b0, conv_ch_o}, 32'd1);
            dack_i[0] = 1'b1; tc_i = 1'b1;
            @(negedge clk);
            dack_i = 2'b00; tc_i = 1'b0;
            @(negedge clk);
            chk("R10 tc ignored, still busy", {31'b0, busy_o}, 32'd1);
        end
        cfg_dma_en = 1'b0;
        @(negedge clk);
        chk("R11 abort to idle", {29'b0, busy_o, drq_o}, 32'd0);
        cfg_dma_en = 1'b1;
        cfg_no_tc = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule